// File: doc/BRIEF.md
# Auxiliary Stereo Serial Audio Capture Port (Clock Master)

This block receives a two-channel serial audio stream from an external converter or digital-audio receiver and hands the two words to a multi-slot transmitter as auxiliary channels 1 and 2. It always drives the bit clock and the left/right frame clock itself. Both clocks come from a system clock that runs at 256 times the sample rate. The bit clock is the system clock divided by four, so each frame holds 64 bit periods, 32 for each channel.

Two inputs set how the stream is decoded. The first selects left-justified or I2S framing. The second sets a word length from 16 to 24 bits. The block reads both inputs once per frame, at the frame boundary. It captures each channel into its own 24-bit accumulator, MSB first. At the end of the frame it copies both accumulators to the outputs in the same cycle and raises a one-cycle strobe.

Top module: `aux_rx_master`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both output words are zero, the strobe is low and the bit clock is low. The frame clock is high, which is the left-channel level of the reset format. The reset format is left-justified with 24-bit words.
- R2: The bit clock is low for 2 system clocks and then high for 2, a period of 4. A frame holds 64 bit periods. The frame clock changes only when the bit clock falls, once every 32 bit periods.
- R3: In left-justified format the frame clock is high during the left half-frame. In I2S format it is low during the left half-frame. The left half is always the first half after reset.
- R4: In left-justified format the MSB of each channel is the bit sampled on the first bit-clock rising edge of its half-frame.
- R5: In I2S format the MSB is sampled on the second bit-clock rising edge of its half-frame. The bit on the first rising edge is ignored.
- R6: The word length input is a 5-bit binary count. Values from 16 to 24 are used as given. Values below 16 act as 16, and values above 24 act as 24.
- R7: A word of length N lands in bits 23 down to 24-N of its output. The lower bits are zero. Serial bits after the N-th bit of a half-frame have no effect.
- R8: The left word appears on aux channel 1 and the right word on aux channel 2. Both change together, only in the cycle in which the one-cycle strobe is high. The strobe rises once per frame, one system clock after the 64th bit-clock rising edge of that frame.
- R9: A frame is decoded with the format and length present on the inputs in the last system clock of the previous frame. Changes made during a frame do not affect that frame.
- R10: The serial input is sampled at the system clock edge at which the bit clock rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 x sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i2s | input | 1 | 1 = I2S framing, 0 = left-justified |
| cfg_len | input | 5 | Word length in bits, 16 to 24 |
| sdin | input | 1 | Serial audio data from the external device |
| bclk | output | 1 | Generated bit clock, 64 x sample rate |
| lrck | output | 1 | Generated left/right frame clock |
| aux1_word | output | 24 | Left-channel sample, left-aligned |
| aux2_word | output | 24 | Right-channel sample, left-aligned |
| aux_valid | output | 1 | One-cycle strobe when both words update |

## Verification
An off-by-one in the frame counter or in the bit-position logic shows in the first frame after reset. The words come out shifted by one bit, or the frame clock takes the wrong level during a half-frame, and the scoreboard sees either within 256 system clocks. A wrong latched format or length shows as a wrong word at the next strobe. Stray low-order bits give themselves away because the stimulus fills every unused slot with ones, so any leak breaks the zero fill in the same frame.

// File: rtl/aux_rx_pkg.sv
package aux_rx_pkg;

    localparam int AUX_SAMPLE_W = 24;
    localparam int AUX_MIN_LEN  = 16;
    localparam int AUX_LEN_W    = 5;

    typedef struct packed {
        logic                 i2s;
        logic [AUX_LEN_W-1:0] len;
    } aux_cfg_t;

    function automatic logic [AUX_LEN_W-1:0] clamp_len(input logic [AUX_LEN_W-1:0] raw);
        if (int'(raw) < AUX_MIN_LEN) begin
            return AUX_LEN_W'(AUX_MIN_LEN);
        end else if (int'(raw) > AUX_SAMPLE_W) begin
            return AUX_LEN_W'(AUX_SAMPLE_W);
        end
        return raw;
    endfunction

endpackage

// File: rtl/aux_rx_clkgen.sv
module aux_rx_clkgen #(
    parameter int DIV_LOG2  = 2,
    parameter int HALF_LOG2 = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 bclk,
    output logic                 half,
    output logic [HALF_LOG2-1:0] slot_pos,
    output logic                 sample_en,
    output logic                 xfer_en,
    output logic                 frame_last
);
    localparam int CNT_W = 1 + HALF_LOG2 + DIV_LOG2;
    localparam logic [DIV_LOG2-1:0] SAMPLE_PH = DIV_LOG2'((2 ** (DIV_LOG2 - 1)) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } clk_state_t;

    clk_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk       = st_q.cnt[DIV_LOG2-1];
    assign half       = st_q.cnt[CNT_W-1];
    assign slot_pos   = st_q.cnt[CNT_W-2:DIV_LOG2];
    assign sample_en  = (st_q.cnt[DIV_LOG2-1:0] == SAMPLE_PH);
    assign xfer_en    = sample_en && half && (slot_pos == '1);
    assign frame_last = (st_q.cnt == '1);

endmodule

// File: rtl/aux_rx_capture.sv
module aux_rx_capture #(
    parameter int SAMPLE_W  = aux_rx_pkg::AUX_SAMPLE_W,
    parameter int HALF_LOG2 = 5,
    parameter int LEN_W     = aux_rx_pkg::AUX_LEN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic                 xfer_en,
    input  logic                 half,
    input  logic [HALF_LOG2-1:0] slot_pos,
    input  logic                 i2s,
    input  logic [LEN_W-1:0]     wlen,
    input  logic                 sdin,
    output logic [SAMPLE_W-1:0]  word_l,
    output logic [SAMPLE_W-1:0]  word_r,
    output logic                 word_vld
);
    localparam int POS_W = HALF_LOG2 + 1;

    typedef struct packed {
        logic [SAMPLE_W-1:0] acc_l;
        logic [SAMPLE_W-1:0] acc_r;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
        logic                vld;
    } cap_state_t;

    cap_state_t st_q, st_d;

    logic [POS_W-1:0] pos_ext;
    logic [POS_W-1:0] bit_k;
    logic             in_word;
    int               bit_idx;

    always_comb begin
        pos_ext = {1'b0, slot_pos};
        bit_k   = pos_ext - POS_W'(i2s);
        in_word = (pos_ext >= POS_W'(i2s)) && (bit_k < POS_W'(wlen));
        bit_idx = SAMPLE_W - 1 - int'(bit_k);

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (sample_en) begin
            if (slot_pos == '0) begin
                if (half) st_d.acc_r = '0;
                else      st_d.acc_l = '0;
            end
            if (in_word) begin
                for (int i = 0; i < SAMPLE_W; i++) begin
                    if (i == bit_idx) begin
                        if (half) st_d.acc_r[i] = sdin;
                        else      st_d.acc_l[i] = sdin;
                    end
                end
            end
        end
        if (xfer_en) begin
            st_d.out_l = st_q.acc_l;
            st_d.out_r = st_q.acc_r;
            st_d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_l   = st_q.out_l;
    assign word_r   = st_q.out_r;
    assign word_vld = st_q.vld;

endmodule

// File: rtl/aux_rx_master.sv
module aux_rx_master #(
    parameter int SAMPLE_W  = aux_rx_pkg::AUX_SAMPLE_W,
    parameter int LEN_W     = aux_rx_pkg::AUX_LEN_W,
    parameter int DIV_LOG2  = 2,
    parameter int HALF_LOG2 = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_i2s,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                sdin,
    output logic                bclk,
    output logic                lrck,
    output logic [SAMPLE_W-1:0] aux1_word,
    output logic [SAMPLE_W-1:0] aux2_word,
    output logic                aux_valid
);
    import aux_rx_pkg::*;

    aux_cfg_t cfg_q, cfg_d;

    logic                 half;
    logic [HALF_LOG2-1:0] slot_pos;
    logic                 sample_en;
    logic                 xfer_en;
    logic                 frame_last;

    aux_rx_clkgen #(
        .DIV_LOG2  (DIV_LOG2),
        .HALF_LOG2 (HALF_LOG2)
    ) i_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .half       (half),
        .slot_pos   (slot_pos),
        .sample_en  (sample_en),
        .xfer_en    (xfer_en),
        .frame_last (frame_last)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (frame_last) begin
            cfg_d.i2s = cfg_i2s;
            cfg_d.len = clamp_len(cfg_len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.i2s <= 1'b0;
            cfg_q.len <= LEN_W'(SAMPLE_W);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lrck = cfg_q.i2s ? half : ~half;

    aux_rx_capture #(
        .SAMPLE_W  (SAMPLE_W),
        .HALF_LOG2 (HALF_LOG2),
        .LEN_W     (LEN_W)
    ) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .xfer_en   (xfer_en),
        .half      (half),
        .slot_pos  (slot_pos),
        .i2s       (cfg_q.i2s),
        .wlen      (cfg_q.len),
        .sdin      (sdin),
        .word_l    (aux1_word),
        .word_r    (aux2_word),
        .word_vld  (aux_valid)
    );

endmodule

// File: rtl/aux_rx_checker.sv
module aux_rx_checker #(
    parameter int SAMPLE_W = aux_rx_pkg::AUX_SAMPLE_W,
    parameter int LEN_W    = aux_rx_pkg::AUX_LEN_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bclk,
    input logic                lrck,
    input logic                aux_valid,
    input logic [SAMPLE_W-1:0] aux1_word,
    input logic [SAMPLE_W-1:0] aux2_word,
    input logic                cfg_i2s_q,
    input logic [LEN_W-1:0]    cfg_len_q
);
    logic [SAMPLE_W-1:0] low_mask;
    assign low_mask = ~({SAMPLE_W{1'b1}} << (SAMPLE_W - int'(cfg_len_q)));

    AST_BCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |=> bclk) else $error("bclk high phase too short"); // R2
    AST_BCLK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk) |=> !bclk) else $error("bclk low phase too short"); // R2
    AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck) |-> $fell(bclk)) else $error("lrck moved off a bclk fall"); // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        aux_valid |=> !aux_valid) else $error("strobe longer than one cycle"); // R8
    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_valid |-> ($stable(aux1_word) && $stable(aux2_word))) else $error("words changed without strobe"); // R8
    AST_VALID_IN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        aux_valid |-> (bclk && (lrck == cfg_i2s_q))) else $error("strobe outside right half"); // R3
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        aux_valid |-> (((aux1_word | aux2_word) & low_mask) == '0)) else $error("low bits not zero"); // R7
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_len_q) >= 16) && (int'(cfg_len_q) <= SAMPLE_W)) else $error("length out of range"); // R6

endmodule

bind aux_rx_master aux_rx_checker #(
    .SAMPLE_W (SAMPLE_W),
    .LEN_W    (LEN_W)
) i_aux_rx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk      (bclk),
    .lrck      (lrck),
    .aux_valid (aux_valid),
    .aux1_word (aux1_word),
    .aux2_word (aux2_word),
    .cfg_i2s_q (cfg_q.i2s),
    .cfg_len_q (cfg_q.len)
);

// File: tb/test_aux_rx_master.sv
`timescale 1ns/1ps
module test_aux_rx_master;
    localparam int NF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_i2s = 1'b0;
    logic [4:0]  cfg_len = 5'd24;
    logic        sdin = 1'b1;
    logic        bclk, lrck, aux_valid;
    logic [23:0] aux1_word, aux2_word;

    int total = 0;
    int bad = 0;
    int popped = 0;
    int rises = 0;
    realtime last_rise = 0;

    logic [23:0] smp_l [NF];
    logic [23:0] smp_r [NF];
    logic        f_i2s [NF];
    logic [4:0]  f_len [NF];
    logic        bits  [64];
    logic [47:0] exp_q [$];

    always #4 clk = ~clk;

    aux_rx_master i_aux_rx_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i2s   (cfg_i2s),
        .cfg_len   (cfg_len),
        .sdin      (sdin),
        .bclk      (bclk),
        .lrck      (lrck),
        .aux1_word (aux1_word),
        .aux2_word (aux2_word),
        .aux_valid (aux_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int eff_len(input logic [4:0] raw);
        if (raw < 5'd16) return 16;
        if (raw > 5'd24) return 24;
        return int'(raw);
    endfunction

    // Driver: builds the serial slots of frame f and pushes the expected words
    task automatic build_frame(input int f);
        int          wl;
        int          d;
        logic [23:0] mask;
        logic [23:0] s;
        if (f >= NF) begin
            for (int p = 0; p < 64; p++) bits[p] = 1'b0;
            return;
        end
        wl   = eff_len(f_len[f]);
        d    = f_i2s[f] ? 1 : 0;
        mask = 24'hFFFFFF << (24 - wl);
        for (int h = 0; h < 2; h++) begin
            s = (h == 0) ? smp_l[f] : smp_r[f];
            for (int p = 0; p < 32; p++) begin
                if (p >= d && (p - d) < wl) bits[h*32 + p] = s[23 - (p - d)];
                else                        bits[h*32 + p] = 1'b1;  // junk, must be ignored (R7, R5)
            end
        end
        exp_q.push_back({smp_l[f] & mask, smp_r[f] & mask});
    endtask

    initial begin
        smp_l[0] = 24'hA5C3E1; smp_r[0] = 24'h3C5A97; f_i2s[0] = 0; f_len[0] = 5'd24;
        smp_l[1] = 24'h8001FF; smp_r[1] = 24'h7FFE00; f_i2s[1] = 0; f_len[1] = 5'd16;
        smp_l[2] = 24'h123456; smp_r[2] = 24'hFEDCBA; f_i2s[2] = 1; f_len[2] = 5'd24;
        smp_l[3] = 24'hC0FFEE; smp_r[3] = 24'h0BADF0; f_i2s[3] = 1; f_len[3] = 5'd16;
        smp_l[4] = 24'h9ABCDE; smp_r[4] = 24'h654321; f_i2s[4] = 1; f_len[4] = 5'd20;
        smp_l[5] = 24'hFFFFFF; smp_r[5] = 24'h000001; f_i2s[5] = 0; f_len[5] = 5'd18;
        smp_l[6] = 24'h5A5A5A; smp_r[6] = 24'hA5A5A5; f_i2s[6] = 0; f_len[6] = 5'd31;
        smp_l[7] = 24'h13579B; smp_r[7] = 24'h2468AC; f_i2s[7] = 1; f_len[7] = 5'd3;
        smp_l[8] = 24'h000000; smp_r[8] = 24'hFFFFFF; f_i2s[8] = 0; f_len[8] = 5'd24;
        smp_l[9] = 24'h800000; smp_r[9] = 24'h000100; f_i2s[9] = 1; f_len[9] = 5'd24;
    end

    // Reset checks and serial driver
    initial begin
        int slot;
        int f;
        #0;
        build_frame(0);
        slot = 0;
        f    = 0;
        sdin = bits[0];
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(aux1_word == 0 && aux2_word == 0, "R1 words in reset", {aux1_word, aux2_word}, 48'h0);
        chk(!aux_valid, "R1 strobe in reset", 48'(aux_valid), 48'h0);
        chk(!bclk, "R1 bclk in reset", 48'(bclk), 48'h0);
        chk(lrck, "R1 lrck in reset", 48'(lrck), 48'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bclk && lrck && !aux_valid, "R1 first cycle after reset", {45'h0, bclk, lrck, aux_valid}, 48'h2);
        forever begin
            @(negedge bclk);
            #1;
            slot++;
            if (slot == 64) begin
                slot = 0;
                f++;
                build_frame(f);
            end
            if (slot == 16) begin
                // mid-frame junk config must not be taken (R9)
                cfg_i2s = ~cfg_i2s;
                cfg_len = 5'd17;
            end
            if (slot == 48 && (f + 1) < NF) begin
                cfg_i2s = f_i2s[f + 1];
                cfg_len = f_len[f + 1];
            end
            sdin = bits[slot];
        end
    end

    // Clock monitor: bclk period and lrck level per half (R2, R3, R10)
    always @(posedge bclk) begin
        int fr;
        int s;
        realtime now;
        now = $realtime;
        fr  = rises / 64;
        s   = rises % 64;
        rises++;
        if (rises > 1 && s == 10)
            chk(now - last_rise == 32.0, "R2 bclk period 4 sysclk", 48'(int'(now - last_rise)), 48'd32);
        last_rise = now;
        if (fr < NF) begin
            #1;
            if (s == 5)
                chk(lrck == !f_i2s[fr], "R3 lrck left level", 48'(lrck), 48'(!f_i2s[fr]));
            if (s == 40)
                chk(lrck == f_i2s[fr], "R3 lrck right level", 48'(lrck), 48'(f_i2s[fr]));
        end
    end

    // Scoreboard monitor (R4 R5 R6 R7 R8 R9)
    always @(negedge clk) begin
        logic [47:0] e;
        if (rst_n && aux_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected strobe", {aux1_word, aux2_word}, 48'h0);
            end else begin
                e = exp_q.pop_front();
                chk({aux1_word, aux2_word} == e, "R4 R5 R6 R7 R9 frame words", {aux1_word, aux2_word}, e);
                chk(rises == 64 * (popped + 1), "R8 strobe after 64th rise", 48'(rises), 48'(64 * (popped + 1)));
                popped++;
            end
        end
    end

    initial begin
        wait (popped == NF);
        repeat (8) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        total++;
        bad++;
        $display("FAIL watchdog popped=%0d expected=%0d", popped, NF);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule